// File: doc/BRIEF.md
# Configurable Status and Interrupt Register Bank

This block is a small bank of 16-bit registers for a peripheral's control and status space. Registers are addressed per word. A parameter gives each register one access type:

- software control, readable and writable;
- hardware status, sampled through one flop;
- a pass-through view of a hardware input with no storage;
- level-captured event latches;
- edge-captured interrupt events;
- interrupt enables.

Event bits are either high- or low-sensitive. Each event type clears in one of two ways: by a read of its register, or by a write in which every 1 clears the matching bit.

Software reaches the bank through a simple strobe bus. The bus has an address, a read strobe, a write strobe, write data and combinational read data. Hardware supplies one 16-bit input slice per register. Hardware receives the values of the control and enable registers, and a single registered, active-high interrupt request.

An enable register covers the interrupt register at the address just below it. The default layout places the types as follows:

| Address | Access type |
|---|---|
| 0 | control |
| 1 | status |
| 2 | pass-through |
| 3 | high-latch, read-clear |
| 4 | low-latch, read-clear |
| 5 | high-latch, mask-clear |
| 6 | low-latch, mask-clear |
| 7 | rising-edge interrupt, read-clear |
| 8 | enable for 7 |
| 9 | falling-edge interrupt, mask-clear |
| 10 | enable for 9 |
| 11 | rising-edge interrupt, mask-clear, with no enable |

Top module: `regbank_top`

## Requirements
- R1: Address a selects register a for addresses 0 to 11. Reads of addresses 12 to 15 return zero, and writes to them change nothing.
- R2: Register 0 is a control register. A write stores bus_wdata, a read returns the stored value, and ctrl_out bits [15:0] carry that value.
- R3: Register 1 reads the value that hw_in slice 1 held one clock earlier. A write to it has no effect.
- R4: Register 2 reads hw_in slice 2 in the same cycle. A write to it has no effect.
- R5: In register 3, each bit sets while its hw_in bit is 1. In register 4, each bit sets while its hw_in bit is 0. Both clear on the clock edge that ends a read of the register. The read itself returns the value held before the clear.
- R6: In register 5, bits set on a high input. In register 6, bits set on a low input. Reads do not clear them. A write clears exactly the bits written as 1.
- R7: Register 7 captures rising edges and clears on read. Register 9 captures falling edges and clears by 1-mask write. Register 11 captures rising edges and clears by 1-mask write. A steady input level sets nothing.
- R8: When a set condition and a clear (read or mask write) happen in the same cycle, the bit ends up set.
- R9: Registers 8 and 10 are readable and writable enables for registers 7 and 9. Their values appear on ctrl_out slices 8 and 10.
- R10: irq is high one cycle after any bit of register 7 AND register 8, or of register 9 AND register 10, is 1. Otherwise irq is low. Register 11 never raises irq.
- R11: Reset clears every stored register, ctrl_out and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data or clear mask |
| bus_rdata | output | 16 | Read data of the addressed register |
| hw_in | input | 192 | One 16-bit hardware slice per register, slice n at bits [16n+15:16n] |
| ctrl_out | output | 192 | Control and enable register values, same slicing, zero elsewhere |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a set event that lands in the same cycle as its own clear. The bench arranges this by changing the hardware input just after a clock edge. It then issues the clearing read or mask write in that same cycle, so both meet on the next edge. The one-cycle delay of irq behind the status and enable bits is checked edge by edge. A steady high input is held across a clearing read to show that a level alone does not re-arm an edge interrupt.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int DW   = 16;
    localparam int AW   = 4;
    localparam int NREG = 12;
    localparam int KW   = 4;

    typedef enum logic [KW-1:0] {
        ACC_CTRL, ACC_STAT, ACC_PASS,
        ACC_LVH_RC, ACC_LVL_RC, ACC_LVH_MC, ACC_LVL_MC,
        ACC_EDR_RC, ACC_EDF_RC, ACC_EDR_MC, ACC_EDF_MC,
        ACC_IEN
    } acc_e;

    typedef struct packed {
        logic          rd;
        logic          wr;
        logic [DW-1:0] wdata;
    } cell_req_t;

    function automatic logic is_edge(acc_e k);
        return k inside {ACC_EDR_RC, ACC_EDF_RC, ACC_EDR_MC, ACC_EDF_MC};
    endfunction

    function automatic logic is_level(acc_e k);
        return k inside {ACC_LVH_RC, ACC_LVL_RC, ACC_LVH_MC, ACC_LVL_MC};
    endfunction

    function automatic logic low_sense(acc_e k);
        return k inside {ACC_LVL_RC, ACC_LVL_MC, ACC_EDF_RC, ACC_EDF_MC};
    endfunction

    function automatic logic read_clears(acc_e k);
        return k inside {ACC_LVH_RC, ACC_LVL_RC, ACC_EDR_RC, ACC_EDF_RC};
    endfunction

    function automatic logic drives_ctrl(acc_e k);
        return k inside {ACC_CTRL, ACC_IEN};
    endfunction

    function automatic logic [NREG*KW-1:0] default_layout();
        acc_e kinds [NREG] = '{ACC_CTRL, ACC_STAT, ACC_PASS, ACC_LVH_RC,
                               ACC_LVL_RC, ACC_LVH_MC, ACC_LVL_MC, ACC_EDR_RC,
                               ACC_IEN, ACC_EDF_MC, ACC_IEN, ACC_EDR_MC};
        logic [NREG*KW-1:0] lay = '0;
        for (int i = 0; i < NREG; i++) lay[i*KW +: KW] = kinds[i];
        return lay;
    endfunction

endpackage

// File: rtl/regbank_cell.sv
module regbank_cell
    import regbank_pkg::*;
#(
    parameter acc_e KIND = ACC_CTRL
) (
    input  logic          clk,
    input  logic          rst,
    input  cell_req_t     req,
    input  logic [DW-1:0] hw,
    output logic [DW-1:0] rd_val,
    output logic [DW-1:0] ctrl
);

    logic unused_cell;
    assign unused_cell = ^{clk, rst, req, hw};

    generate
        if (KIND == ACC_CTRL || KIND == ACC_IEN) begin : g_rw
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst)          q <= '0;
                else if (req.wr)  q <= req.wdata;
            end
            assign rd_val = q;
            assign ctrl   = q;
        end else if (KIND == ACC_STAT) begin : g_stat
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= hw;
            end
            assign rd_val = q;
            assign ctrl   = '0;
        end else if (KIND == ACC_PASS) begin : g_pass
            assign rd_val = hw;
            assign ctrl   = '0;
        end else begin : g_event
            logic [DW-1:0] q;
            logic [DW-1:0] set_v;
            logic [DW-1:0] clr_v;
            logic [DW-1:0] sense;

            assign sense = low_sense(KIND) ? ~hw : hw;

            if (is_edge(KIND)) begin : g_edge
                logic [DW-1:0] prev_sense;
                always_ff @(posedge clk) begin
                    if (rst) prev_sense <= '0;
                    else     prev_sense <= sense;
                end
                // a falling edge shows as a rise of the inverted input
                assign set_v = sense & ~prev_sense;
            end else begin : g_lvl
                assign set_v = sense;
            end

            if (read_clears(KIND)) begin : g_rc
                assign clr_v = {DW{req.rd}};
            end else begin : g_mc
                assign clr_v = req.wr ? req.wdata : '0;
            end

            // set has priority over a clear in the same cycle
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= (q & ~clr_v) | set_v;
            end
            assign rd_val = q;
            assign ctrl   = '0;
        end
    endgenerate

endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux
    import regbank_pkg::*;
#(
    parameter int N_REG  = NREG,
    parameter int A_W    = AW,
    parameter int D_W    = DW
) (
    input  logic [A_W-1:0]            addr,
    input  logic [N_REG-1:0][D_W-1:0] vals,
    output logic [D_W-1:0]            rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (addr == A_W'(i)) rdata = vals[i];
        end
    end

endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import regbank_pkg::*;
#(
    parameter logic [NREG*KW-1:0] LAYOUT = default_layout()
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic [NREG*DW-1:0] hw_in,
    output logic [NREG*DW-1:0] ctrl_out,
    output logic               irq
);

    function automatic acc_e kind_at(int a);
        return acc_e'(LAYOUT[a*KW +: KW]);
    endfunction

    function automatic logic has_enable(int a);
        if (a + 1 >= NREG) return 1'b0;
        return is_edge(kind_at(a)) && (kind_at(a + 1) == ACC_IEN);
    endfunction

    logic [NREG-1:0][DW-1:0] vals;
    logic [NREG-1:0]         gate;
    logic                    irq_q;

    genvar a;
    generate
        for (a = 0; a < NREG; a++) begin : g_reg
            cell_req_t req;
            assign req.rd    = bus_rd && (bus_addr == AW'(a));
            assign req.wr    = bus_wr && (bus_addr == AW'(a));
            assign req.wdata = bus_wdata;

            regbank_cell #(.KIND(kind_at(a))) u_cell (
                .clk    (clk),
                .rst    (rst),
                .req    (req),
                .hw     (hw_in[a*DW +: DW]),
                .rd_val (vals[a]),
                .ctrl   (ctrl_out[a*DW +: DW])
            );

            if (has_enable(a)) begin : g_gate
                assign gate[a] = |(vals[a] & vals[a+1]);
            end else begin : g_nogate
                assign gate[a] = 1'b0;
            end
        end
    endgenerate

    regbank_rdmux #(.N_REG(NREG), .A_W(AW), .D_W(DW)) u_rdmux (
        .addr  (bus_addr),
        .vals  (vals),
        .rdata (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |gate;
    end
    assign irq = irq_q;

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
    import regbank_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [AW-1:0]           bus_addr,
    input logic                    bus_rd,
    input logic                    bus_wr,
    input logic [DW-1:0]           bus_rdata,
    input logic [NREG*DW-1:0]      hw_in,
    input logic [NREG-1:0][DW-1:0] vals,
    input logic                    irq
);

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr >= AW'(NREG)) |-> (bus_rdata == '0));                       // R1

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == AW'(0)) |=> $stable(vals[0]));                // R2

    AST_STATUS_LAG: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (vals[1] == $past(hw_in[1*DW +: DW])));                      // R3

    AST_PASS_DIRECT: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == AW'(2)) |-> (bus_rdata == hw_in[2*DW +: DW]));           // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == AW'(3) && hw_in[3*DW +: DW] == '0)
        |=> (vals[3] == '0));                                                  // R5

    AST_MASK_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == AW'(5))
        |=> ((vals[5] & $past(vals[5])) == $past(vals[5])));                  // R6

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (vals[8] == '0 && vals[10] == '0) |=> !irq);                           // R10

    AST_RESET_IRQ: assert property (@(posedge clk)
        rst |=> !irq);                                                         // R11

endmodule

bind regbank_top regbank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .hw_in     (hw_in),
    .vals      (vals),
    .irq       (irq)
);

// File: tb/regbank_top_test.sv
`timescale 1ns/1ps
module regbank_top_test;
    import regbank_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [AW-1:0]      bus_addr = '0;
    logic               bus_rd = 1'b0;
    logic               bus_wr = 1'b0;
    logic [DW-1:0]      bus_wdata = '0;
    logic [DW-1:0]      bus_rdata;
    logic [NREG*DW-1:0] hw = '0;
    logic [NREG*DW-1:0] ctrl_out;
    logic               irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    always #2 clk = ~clk;

    regbank_top uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_in(hw), .ctrl_out(ctrl_out), .irq(irq)
    );

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: one expected item per read cycle
    always @(negedge clk) begin
        if (!rst && bus_rd) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected read", bus_rdata, '0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    // all tasks start and end 1 ns after a rising edge
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic rd(int a, logic [DW-1:0] exp, string tag);
        bus_addr = AW'(a); bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        step();
        bus_rd = 1'b0;
    endtask

    task automatic wr(int a, logic [DW-1:0] d);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic set_hw(int r, logic [DW-1:0] v);
        hw[r*DW +: DW] = v;
    endtask

    initial begin
        #150000;
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        set_hw(4, 16'hFFFF); set_hw(6, 16'hFFFF); set_hw(9, 16'hFFFF);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R11 reset state
        check("R11 irq", {15'd0, irq}, 16'd0);
        check("R11 ctrl0", ctrl_out[0 +: DW], 16'd0);
        for (int i = 0; i < NREG; i++) rd(i, 16'h0000, "R11 reset read");

        // R2 control register
        wr(0, 16'hA5A5);
        rd(0, 16'hA5A5, "R2 readback");
        check("R2 ctrl_out", ctrl_out[0 +: DW], 16'hA5A5);
        check("R2 ctrl_out other", ctrl_out[3*DW +: DW], 16'h0000);

        // R1 unmapped
        wr(12, 16'hFFFF);
        rd(12, 16'h0000, "R1 unmapped 12");
        rd(15, 16'h0000, "R1 unmapped 15");
        rd(0, 16'hA5A5, "R1 no alias");

        // R3 status lag, R4 pass-through in same cycle
        set_hw(1, 16'hBEEF); set_hw(2, 16'h00F0);
        rd(1, 16'h0000, "R3 old value same cycle");
        rd(1, 16'hBEEF, "R3 new value next cycle");
        wr(1, 16'h1111);
        rd(1, 16'hBEEF, "R3 write ignored");
        wr(2, 16'h1234);
        rd(2, 16'h00F0, "R4 pass-through");

        // R5 read-clear latches
        set_hw(3, 16'h0011); step(); set_hw(3, 16'h0000);
        rd(3, 16'h0011, "R5 high latch set");
        rd(3, 16'h0000, "R5 cleared by read");
        set_hw(4, 16'hFFFE); step(); set_hw(4, 16'hFFFF);
        rd(4, 16'h0001, "R5 low latch set");
        rd(4, 16'h0000, "R5 low cleared by read");

        // R8 set wins over read clear
        set_hw(3, 16'h0100);
        rd(3, 16'h0000, "R8 pre value");
        set_hw(3, 16'h0000);
        rd(3, 16'h0100, "R8 set kept over read clear");

        // R6 mask-clear latches
        set_hw(5, 16'h00F0); step(); set_hw(5, 16'h0000);
        rd(5, 16'h00F0, "R6 high mask latch set");
        rd(5, 16'h00F0, "R6 read does not clear");
        wr(5, 16'h0030);
        rd(5, 16'h00C0, "R6 only 1 bits cleared");
        set_hw(6, 16'h7FFF); step(); set_hw(6, 16'hFFFF);
        rd(6, 16'h8000, "R6 low mask latch set");
        wr(6, 16'h8000);
        rd(6, 16'h0000, "R6 low mask cleared");

        // R7 rising edge, read clear; R10 disabled
        set_hw(7, 16'h0001); step();
        check("R10 no irq when disabled", {15'd0, irq}, 16'd0);
        step();
        check("R10 still no irq when disabled", {15'd0, irq}, 16'd0);
        rd(7, 16'h0001, "R7 rising captured");
        step();
        rd(7, 16'h0000, "R7 steady level sets nothing");

        // R9 enable register
        wr(8, 16'h0001);
        rd(8, 16'h0001, "R9 enable readback");
        check("R9 ctrl_out enable", ctrl_out[8*DW +: DW], 16'h0001);

        // R10 irq timing
        set_hw(7, 16'h0000); step();
        set_hw(7, 16'h0001); step();
        check("R10 irq one cycle after status", {15'd0, irq}, 16'd0);
        step();
        check("R10 irq asserted", {15'd0, irq}, 16'd1);
        rd(7, 16'h0001, "R7 read before clear");
        check("R10 irq lags clear", {15'd0, irq}, 16'd1);
        step();
        check("R10 irq drops", {15'd0, irq}, 16'd0);

        // R7 falling edge, mask clear, with enable at 10
        set_hw(9, 16'hFFFD); step();
        rd(9, 16'h0002, "R7 falling captured");
        rd(9, 16'h0002, "R7 mask type not read-cleared");
        wr(10, 16'h0002);
        check("R9 ctrl_out enable 10", ctrl_out[10*DW +: DW], 16'h0002);
        step();
        check("R10 irq from reg 9", {15'd0, irq}, 16'd1);
        wr(9, 16'h0002);
        step();
        check("R10 irq after mask clear", {15'd0, irq}, 16'd0);
        rd(9, 16'h0000, "R7 mask cleared");

        // R8 set wins over mask clear
        set_hw(9, 16'hFFFF); step();
        set_hw(9, 16'hFFFB);
        wr(9, 16'h0004);
        rd(9, 16'h0004, "R8 set kept over mask clear");

        // R7 and R10: register 11 without enable
        set_hw(11, 16'h0001); step();
        rd(11, 16'h0001, "R7 reg 11 rising");
        step();
        check("R10 reg 11 never raises irq", {15'd0, irq}, 16'd0);

        step();
        check("scoreboard drained", 16'(exp_q.size()), 16'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule